// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load-Use Interlock

This block holds the hazard logic for a five-stage in-order pipeline with fetch, decode, execute, memory and writeback stages. It reads register numbers and a few control bits from the decode, execute, memory and writeback pipeline registers. From these it decides where each execute-stage ALU operand comes from: the register file, the result still in the memory stage, or the value waiting in the writeback stage. It also detects when an instruction in decode needs the result of a load that is still in execute. In that case it holds the program counter and the decode register and sends a bubble into execute.

The unit is purely combinational, and every output follows its inputs within the same cycle. The surrounding pipeline feeds the outputs into the operand multiplexers, the PC and decode-register write enables, and the clear of the execute-stage control fields. After one stall cycle the load has moved to writeback, and the normal bypass path then delivers its result.

Top module: `hz_unit`

## Requirements
- R1: Operand-select codes are 2'b00 = register file, 2'b10 = result held in the memory stage, 2'b01 = value held in the writeback stage. 2'b11 never appears. When no forwarding condition matches, both codes are 2'b00.
- R2: Operand A selects 2'b10 when the memory-stage write flag is set and its destination is nonzero and equals the execute-stage rs. Operand B follows the same rule against the execute-stage rt.
- R3: No operand is forwarded from a stage whose write flag is clear, or whose destination is register 0.
- R4: An operand selects 2'b01 when the writeback-stage write flag is set, its destination is nonzero and equals the operand's source, and the R2 condition for that operand does not hold.
- R5: When the memory stage and the writeback stage both match the same source, the memory stage wins (2'b10).
- R6: A load-use hazard exists when the execute-stage memory-read flag is set and the execute-stage rt equals the decode-stage rs or rt. During a hazard, pc_we_o = 0, ifid_we_o = 0 and idex_bubble_o = 1.
- R7: Without a hazard, pc_we_o = 1, ifid_we_o = 1 and idex_bubble_o = 0.
- R8: All outputs are combinational. After the bubble has entered execute, the stall drops in the next cycle. One cycle later the dependent instruction receives the load value through the writeback path (2'b01).
- R9: The two operands are decided independently and may select different sources in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_rs_i | input | REG_AW | First source register of the instruction in decode |
| ifid_rt_i | input | REG_AW | Second source register of the instruction in decode |
| idex_rs_i | input | REG_AW | First source register of the instruction in execute |
| idex_rt_i | input | REG_AW | Second source register of the instruction in execute |
| idex_memread_i | input | 1 | Instruction in execute is a load |
| exmem_regwrite_i | input | 1 | Instruction in memory stage writes a register |
| exmem_rd_i | input | REG_AW | Destination of the instruction in memory stage |
| memwb_regwrite_i | input | 1 | Instruction in writeback writes a register |
| memwb_rd_i | input | REG_AW | Destination of the instruction in writeback |
| fwd_a_o | output | 2 | Source select for ALU operand A |
| fwd_b_o | output | 2 | Source select for ALU operand B |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Decode pipeline register write enable |
| idex_bubble_o | output | 1 | Zero the control fields entering execute |

## Verification
The bench builds the unit with the default REG_AW of 5, so it can reach all 32 register numbers. These include register 0, which must never be forwarded, and high numbers, which exercise the full comparator width. A vector table covers single-stage matches, double matches that test priority, a disabled write flag and split operand sources. A directed three-cycle sequence then walks a load through the stall, the bubble and the writeback bypass.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_REG = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic              exm_we_i,
  input  logic [REG_AW-1:0] exm_rd_i,
  input  logic              wb_we_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  output fwd_sel_e          sel_o
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic exm_hit, wb_hit;

  assign exm_hit = exm_we_i && (exm_rd_i != ZERO_REG) && (exm_rd_i == src_i);
  assign wb_hit  = wb_we_i  && (wb_rd_i  != ZERO_REG) && (wb_rd_i  == src_i);

  // newest producer first
  always_comb begin
    if (exm_hit)     sel_o = FWD_MEM;
    else if (wb_hit) sel_o = FWD_WB;
    else             sel_o = FWD_REG;
  end

  always_comb begin
    AST_SEL_LEGAL: assert (sel_o != 2'b11);                               // R1
    AST_NO_ZERO_FWD: assert (src_i != ZERO_REG || sel_o == FWD_REG);      // R3
    AST_MEM_NEEDS_WE: assert (sel_o != FWD_MEM || exm_we_i);              // R2
    AST_WB_NEEDS_WE: assert (sel_o != FWD_WB || wb_we_i);                 // R4
    AST_MEM_PRIORITY: assert (!(exm_hit && sel_o == FWD_WB));             // R5
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_AW = 5
) (
  input  logic              load_in_ex_i,
  input  logic [REG_AW-1:0] ex_dst_i,
  input  logic [REG_AW-1:0] id_rs_i,
  input  logic [REG_AW-1:0] id_rt_i,
  output logic              stall_o
);
  assign stall_o = load_in_ex_i && ((ex_dst_i == id_rs_i) || (ex_dst_i == id_rt_i));

  always_comb begin
    AST_STALL_NEEDS_LOAD: assert (!stall_o || load_in_ex_i);              // R6
  end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ifid_rs_i,
  input  logic [REG_AW-1:0] ifid_rt_i,
  input  logic [REG_AW-1:0] idex_rs_i,
  input  logic [REG_AW-1:0] idex_rt_i,
  input  logic              idex_memread_i,
  input  logic              exmem_regwrite_i,
  input  logic [REG_AW-1:0] exmem_rd_i,
  input  logic              memwb_regwrite_i,
  input  logic [REG_AW-1:0] memwb_rd_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              pc_we_o,
  output logic              ifid_we_o,
  output logic              idex_bubble_o
);
  localparam int NUM_OPS = 2;

  logic [REG_AW-1:0] op_src [NUM_OPS];
  fwd_sel_e          op_sel [NUM_OPS];
  logic              stall;

  assign op_src[0] = idex_rs_i;
  assign op_src[1] = idex_rt_i;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    hz_fwd_sel #(.REG_AW(REG_AW)) u_sel (
      .src_i    (op_src[g]),
      .exm_we_i (exmem_regwrite_i),
      .exm_rd_i (exmem_rd_i),
      .wb_we_i  (memwb_regwrite_i),
      .wb_rd_i  (memwb_rd_i),
      .sel_o    (op_sel[g])
    );
  end

  hz_load_use #(.REG_AW(REG_AW)) u_lu (
    .load_in_ex_i (idex_memread_i),
    .ex_dst_i     (idex_rt_i),
    .id_rs_i      (ifid_rs_i),
    .id_rt_i      (ifid_rt_i),
    .stall_o      (stall)
  );

  assign fwd_a_o       = op_sel[0];
  assign fwd_b_o       = op_sel[1];
  assign pc_we_o       = ~stall;
  assign ifid_we_o     = ~stall;
  assign idex_bubble_o = stall;

  always_comb begin
    AST_STALL_CONSISTENT: assert (pc_we_o == ifid_we_o && pc_we_o != idex_bubble_o); // R6
    AST_IDLE_NO_FWD: assert (exmem_regwrite_i || memwb_regwrite_i ||
                             (fwd_a_o == 2'b00 && fwd_b_o == 2'b00));                 // R3
    AST_NO_LOAD_NO_STALL: assert (idex_memread_i || pc_we_o);                         // R7
  end
endmodule

// File: tb/tb_hz_unit.sv
module tb_hz_unit;
  localparam int AW = 5;

  typedef struct packed {
    logic [AW-1:0] ifid_rs;
    logic [AW-1:0] ifid_rt;
    logic [AW-1:0] idex_rs;
    logic [AW-1:0] idex_rt;
    logic          mr;
    logic          xw;
    logic [AW-1:0] xrd;
    logic          ww;
    logic [AW-1:0] wrd;
    logic [1:0]    ea;
    logic [1:0]    eb;
    logic          es;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0,  1'b0, 5'd0,  2'b00, 2'b00, 1'b0},
    '{5'd0, 5'd0, 5'd3, 5'd4, 1'b0, 1'b1, 5'd3,  1'b0, 5'd0,  2'b10, 2'b00, 1'b0},
    '{5'd0, 5'd0, 5'd3, 5'd4, 1'b0, 1'b1, 5'd4,  1'b0, 5'd0,  2'b00, 2'b10, 1'b0},
    '{5'd0, 5'd0, 5'd3, 5'd3, 1'b0, 1'b0, 5'd3,  1'b0, 5'd3,  2'b00, 2'b00, 1'b0},
    '{5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00, 1'b0},
    '{5'd0, 5'd0, 5'd5, 5'd6, 1'b0, 1'b0, 5'd0,  1'b1, 5'd6,  2'b00, 2'b01, 1'b0},
    '{5'd0, 5'd0, 5'd7, 5'd7, 1'b0, 1'b1, 5'd7,  1'b1, 5'd7,  2'b10, 2'b10, 1'b0},
    '{5'd0, 5'd0, 5'd7, 5'd8, 1'b0, 1'b1, 5'd8,  1'b1, 5'd7,  2'b01, 2'b10, 1'b0},
    '{5'd9, 5'd1, 5'd2, 5'd9, 1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  2'b00, 2'b00, 1'b1},
    '{5'd1, 5'd9, 5'd2, 5'd9, 1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  2'b00, 2'b00, 1'b1},
    '{5'd1, 5'd2, 5'd2, 5'd9, 1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  2'b00, 2'b00, 1'b0},
    '{5'd9, 5'd1, 5'd2, 5'd9, 1'b0, 1'b0, 5'd0,  1'b0, 5'd0,  2'b00, 2'b00, 1'b0},
    '{5'd0, 5'd0, 5'd3, 5'd4, 1'b0, 1'b1, 5'd2,  1'b1, 5'd5,  2'b00, 2'b00, 1'b0},
    '{5'd0, 5'd0, 5'd31,5'd4, 1'b0, 1'b0, 5'd31, 1'b1, 5'd31, 2'b01, 2'b00, 1'b0}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] ifid_rs, ifid_rt, idex_rs, idex_rt, xrd, wrd;
  logic          mr, xw, ww;
  logic [1:0]    fwd_a, fwd_b;
  logic          pc_we, ifid_we, bubble;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  hz_unit #(.REG_AW(AW)) dut (
    .ifid_rs_i        (ifid_rs),
    .ifid_rt_i        (ifid_rt),
    .idex_rs_i        (idex_rs),
    .idex_rt_i        (idex_rt),
    .idex_memread_i   (mr),
    .exmem_regwrite_i (xw),
    .exmem_rd_i       (xrd),
    .memwb_regwrite_i (ww),
    .memwb_rd_i       (wrd),
    .fwd_a_o          (fwd_a),
    .fwd_b_o          (fwd_b),
    .pc_we_o          (pc_we),
    .ifid_we_o        (ifid_we),
    .idex_bubble_o    (bubble)
  );

  function automatic string tag_of(int i);
    case (i)
      0, 12:    return "R1";
      1, 2:     return "R2";
      3, 4:     return "R3";
      5, 13:    return "R4";
      6:        return "R5";
      7:        return "R9";
      8, 9:     return "R6";
      default:  return "R7";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    @(negedge clk);
    ifid_rs = v.ifid_rs; ifid_rt = v.ifid_rt;
    idex_rs = v.idex_rs; idex_rt = v.idex_rt;
    mr = v.mr; xw = v.xw; xrd = v.xrd; ww = v.ww; wrd = v.wrd;
    #2;
  endtask

  task automatic check_all(string req, vec_t v);
    chk(req, "fwd_a", fwd_a, v.ea);
    chk(req, "fwd_b", fwd_b, v.eb);
    chk(req, "pc_we", {1'b0, pc_we}, {1'b0, ~v.es});
    chk(req, "ifid_we", {1'b0, ifid_we}, {1'b0, ~v.es});
    chk(req, "bubble", {1'b0, bubble}, {1'b0, v.es});
  endtask

  initial begin
    vec_t v;
    // reset-like idle state: all fields zero, R1 and R7
    v = '0;
    apply(v);
    check_all("R1", v);
    check_all("R7", v);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check_all(tag_of(i), VECS[i]);
    end

    // R8: load r9 in EX, dependent reads r9 in ID -> stall
    v = '0; v.ifid_rs = 5'd9; v.ifid_rt = 5'd3; v.idex_rs = 5'd1; v.idex_rt = 5'd9; v.mr = 1'b1;
    v.es = 1'b1;
    apply(v);
    check_all("R8", v);
    // bubble in EX, load in MEM, dependent held in ID -> stall drops
    v = '0; v.ifid_rs = 5'd9; v.ifid_rt = 5'd3; v.idex_rs = 5'd1; v.idex_rt = 5'd9; v.mr = 1'b0;
    v.xw = 1'b1; v.xrd = 5'd9; v.ea = 2'b00; v.eb = 2'b10; v.es = 1'b0;
    apply(v);
    check_all("R8", v);
    // dependent in EX, bubble in MEM, load in WB -> operand A from writeback
    v = '0; v.idex_rs = 5'd9; v.idex_rt = 5'd3; v.ww = 1'b1; v.wrd = 5'd9;
    v.ea = 2'b01; v.eb = 2'b00;
    apply(v);
    check_all("R8", v);

    // R6 corner: load to r0 still stalls a reader of r0
    v = '0; v.ifid_rt = 5'd0; v.ifid_rs = 5'd4; v.idex_rt = 5'd0; v.mr = 1'b1; v.es = 1'b1;
    apply(v);
    check_all("R6", v);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule